// File: doc/BRIEF.md
# Congestion Duration Counter

This block measures how long a receive input queue stays congested. A one-bit congestion flag, produced elsewhere, and a programmable period value N feed a divide-by-N prescaler. While the flag is high, the prescaler counts clock cycles and adds one to a 32-bit duration register each time N cycles have elapsed. A period of zero turns counting off. The register therefore holds the congested time in units of N clocks.

The register stops at all-ones and does not wrap. Software sees it through single-cycle strobes. A read strobe returns the current value on the read-data port in that same cycle and clears the register at the next edge. A write strobe loads a test value. The read-data port always shows the live register value, so the count can be watched without clearing it.

Top module: `cngc_top`

## Requirements
- R1: After reset the duration register reads 0x0000_0000.
- R2: While `congested` is high and `period` is N (non-zero), the register increases by exactly one every N clock cycles. The prescaler starts from zero at the first congested cycle, and the register never changes by more than one in a cycle without a strobe. While `congested` is low and no strobe is active, the register holds.
- R3: When `period` is 0, no increments occur and the register holds its value.
- R4: The register saturates at 0xFFFF_FFFF and stays there while congestion continues. It never wraps to zero on its own.
- R5: In the cycle that `rd_stb` is high, `rd_data` shows the register value from before the clear. After that edge the register is 0.
- R6: A `wr_stb` loads `wr_data` exactly. It takes priority over a simultaneous read-clear and a simultaneous increment.
- R7: If a read-clear and an increment pulse fall in the same cycle, the register becomes 1 rather than 0.
- R8: A new `period` value takes effect at the next prescaler restart. If the prescaler count already reaches the new N, an increment occurs at the next edge and the prescaler restarts.
- R9: Lowering `congested` resets the prescaler to zero, so a partial period is discarded.

Each "cycle" is one `clk` rising edge. The register value is the value observed on `rd_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| congested | input | 1 | Queue congestion state; counting is active while high |
| period | input | PER_W (16) | Prescale period N; 0 disables counting |
| rd_stb | input | 1 | Read strobe; clears the register at the next edge |
| wr_stb | input | 1 | Write strobe; loads `wr_data` |
| wr_data | input | CNT_W (32) | Value to load on a write |
| rd_data | output | CNT_W (32) | Live register value, pre-clear during a read |

## Verification
The hardest situations to reach are the collisions: an increment pulse landing in the same edge as a read-clear or a write, and a period change while the prescaler is partway through a period. The bench reaches these by running with N=1, so that every congested edge carries a pulse, and raising the strobes at that moment. It reaches saturation by preloading 0xFFFF_FFFE through the write strobe instead of counting there. For the period change, it stops the prescaler at a known phase under a large N and then drops N below that phase.

// File: rtl/cngc_pkg.sv
package cngc_pkg;

   // Operation selected for the duration register in one cycle
   typedef enum logic [1:0] {
      OP_HOLD  = 2'd0,
      OP_LOAD  = 2'd1,
      OP_CLEAR = 2'd2,
      OP_STEP  = 2'd3
   } cngc_op_e;

   // Priority resolution: write over read-clear over increment
   function automatic cngc_op_e cngc_pick_op(input logic wr, input logic rd, input logic inc);
      if (wr)       return OP_LOAD;
      else if (rd)  return OP_CLEAR;
      else if (inc) return OP_STEP;
      else          return OP_HOLD;
   endfunction

endpackage

// File: rtl/cngc_prescaler.sv
module cngc_prescaler #(
   parameter int PER_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic [PER_W-1:0] period,
   output logic             tick
);
   localparam int EXT_W = PER_W + 1;

   logic [PER_W-1:0] phase_q;
   logic [EXT_W-1:0] phase_next_ext;
   logic             run;

   assign run            = active && (period != '0);
   assign phase_next_ext = {1'b0, phase_q} + EXT_W'(1);
   // Restart when the elapsed count reaches or passes N
   assign tick           = run && (phase_next_ext >= {1'b0, period});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       phase_q <= '0;
      else if (!run)    phase_q <= '0;
      else if (tick)    phase_q <= '0;
      else              phase_q <= phase_next_ext[PER_W-1:0];
   end

endmodule

// File: rtl/cngc_accum.sv
module cngc_accum
   import cngc_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             rd_stb,
   input  logic             wr_stb,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] value
);
   localparam logic [CNT_W-1:0] TOP = '1;

   logic [CNT_W-1:0] cnt_q;
   cngc_op_e         op;
   logic             at_top;

   assign at_top = (cnt_q == TOP);
   assign op     = cngc_pick_op(wr_stb, rd_stb, tick);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else begin
         unique case (op)
            OP_LOAD:  cnt_q <= wr_data;
            OP_CLEAR: cnt_q <= tick ? CNT_W'(1) : '0;
            OP_STEP:  cnt_q <= at_top ? cnt_q : cnt_q + CNT_W'(1);
            default:  cnt_q <= cnt_q;
         endcase
      end
   end

   assign value = cnt_q;

endmodule

// File: rtl/cngc_top.sv
module cngc_top #(
   parameter int CNT_W = 32,
   parameter int PER_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             congested,
   input  logic [PER_W-1:0] period,
   input  logic             rd_stb,
   input  logic             wr_stb,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] rd_data
);
   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("cngc_top: CNT_W must be at least 2");
      end
      if (PER_W < 1 || PER_W > 31) begin : g_bad_per
         $error("cngc_top: PER_W must lie in 1..31");
      end
   endgenerate

   logic tick;

   cngc_prescaler #(.PER_W(PER_W)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (congested),
      .period (period),
      .tick   (tick)
   );

   cngc_accum #(.CNT_W(CNT_W)) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .rd_stb  (rd_stb),
      .wr_stb  (wr_stb),
      .wr_data (wr_data),
      .value   (rd_data)
   );

endmodule

// File: rtl/cngc_chk.sv
module cngc_chk #(
   parameter int CNT_W = 32,
   parameter int PER_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             congested,
   input logic [PER_W-1:0] period,
   input logic             rd_stb,
   input logic             wr_stb,
   input logic [CNT_W-1:0] wr_data,
   input logic [CNT_W-1:0] rd_data
);
   localparam logic [CNT_W-1:0] TOP = '1;

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!congested && !rd_stb && !wr_stb) |=> $stable(rd_data)); // R2

   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_stb && !wr_stb) |=> (rd_data == $past(rd_data) || rd_data == $past(rd_data) + CNT_W'(1))); // R2

   AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (period == '0 && !rd_stb && !wr_stb) |=> $stable(rd_data)); // R3

   AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data == TOP && !rd_stb && !wr_stb) |=> (rd_data == TOP)); // R4

   AST_RD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && !wr_stb) |=> (rd_data <= CNT_W'(1))); // R5

   AST_WR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> (rd_data == $past(wr_data))); // R6

endmodule

bind cngc_top cngc_chk #(.CNT_W(CNT_W), .PER_W(PER_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .congested (congested),
   .period    (period),
   .rd_stb    (rd_stb),
   .wr_stb    (wr_stb),
   .wr_data   (wr_data),
   .rd_data   (rd_data)
);

// File: tb/tb_cngc_top.sv
module tb_cngc_top;
   localparam int CNT_W = 32;
   localparam int PER_W = 16;
   localparam int NV    = 8;

   // Vector table: period N, congested cycles, expected count
   localparam int V_PER [NV] = '{1, 2, 3, 4, 5, 0, 7, 16};
   localparam int V_LEN [NV] = '{10, 10, 10, 3, 5, 12, 20, 40};
   localparam int V_EXP [NV] = '{10, 5, 3, 0, 1, 0, 2, 2};

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             congested = 1'b0;
   logic [PER_W-1:0] period = '0;
   logic             rd_stb = 1'b0;
   logic             wr_stb = 1'b0;
   logic [CNT_W-1:0] wr_data = '0;
   logic [CNT_W-1:0] rd_data;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;   // 250 MHz

   cngc_top #(.CNT_W(CNT_W), .PER_W(PER_W)) dut (
      .clk(clk), .rst_n(rst_n), .congested(congested), .period(period),
      .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_data(wr_data), .rd_data(rd_data)
   );

   task automatic chk(input string req, input logic [CNT_W-1:0] act, input logic [CNT_W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic load(input logic [CNT_W-1:0] v);
      wr_stb = 1'b1; wr_data = v;
      @(negedge clk);
      wr_stb = 1'b0;
   endtask

   task automatic cong_for(input int n);
      congested = 1'b1;
      repeat (n) @(negedge clk);
      congested = 1'b0;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      chk("R1 reset value", rd_data, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release", rd_data, 32'h0);

      // R2 / R3: table walk
      for (int i = 0; i < NV; i++) begin
         rd_stb = 1'b1;
         @(negedge clk);
         rd_stb = 1'b0;
         period = PER_W'(V_PER[i]);
         cong_for(V_LEN[i]);
         chk($sformatf("R2 vector %0d (R3 when N=0)", i), rd_data, CNT_W'(V_EXP[i]));
      end

      // R9: partial period discarded when congestion drops
      load(32'h0);
      period = 16'd4;
      cong_for(3);
      @(negedge clk);
      cong_for(3);
      chk("R9 partial periods dropped", rd_data, 32'h0);
      cong_for(4);
      chk("R9 full period after restart", rd_data, 32'h1);

      // R3: N=0 holds a loaded value
      load(32'd7);
      period = 16'd0;
      cong_for(10);
      chk("R3 disabled hold", rd_data, 32'd7);

      // R4: saturation
      load(32'hFFFF_FFFE);
      period = 16'd1;
      cong_for(5);
      chk("R4 saturate", rd_data, 32'hFFFF_FFFF);
      cong_for(3);
      chk("R4 stays at top", rd_data, 32'hFFFF_FFFF);

      // R5: read returns pre-clear value, then clears
      rd_stb = 1'b1;
      #1;
      chk("R5 pre-clear read data", rd_data, 32'hFFFF_FFFF);
      @(negedge clk);
      rd_stb = 1'b0;
      chk("R5 cleared", rd_data, 32'h0);

      // R7: read-clear with simultaneous increment
      load(32'd50);
      period = 16'd1;
      congested = 1'b1;
      rd_stb = 1'b1;
      #1;
      chk("R7 read shows old value", rd_data, 32'd50);
      @(negedge clk);
      congested = 1'b0;
      rd_stb = 1'b0;
      chk("R7 increment kept", rd_data, 32'd1);

      // R6: write beats read and increment
      congested = 1'b1;
      rd_stb = 1'b1;
      wr_stb = 1'b1;
      wr_data = 32'h0000_1234;
      @(negedge clk);
      congested = 1'b0;
      rd_stb = 1'b0;
      wr_stb = 1'b0;
      chk("R6 write priority", rd_data, 32'h0000_1234);

      // R8: period lowered below current phase
      load(32'h0);
      period = 16'd8;
      cong_for(5);
      chk("R8 before change", rd_data, 32'h0);
      period = 16'd3;
      congested = 1'b1;
      @(negedge clk);
      chk("R8 immediate restart", rd_data, 32'h1);
      repeat (3) @(negedge clk);
      congested = 1'b0;
      chk("R8 new period applies", rd_data, 32'h2);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule